// File: doc/BRIEF.md
# SDRAM Command Legality Checker with Two-Bank Tracking

This block watches the control pins of a synchronous DRAM on every rising clock edge and turns the chip select, row strobe, column strobe, write enable and clock enable levels into a decoded command code. It keeps a model of which banks are open and which row each open bank holds. It also keeps the burst length last programmed through the mode register. With this model it judges every command against the device's ordering and spacing rules and flags any command that breaks them.

Spacing limits are module parameters counted in clock cycles. They cover activate to column access, activate to activate on the same bank and on the other bank, precharge to activate, and activate to precharge. A flagged command is reported as a one-cycle pulse with a reason code. It leaves the bank model untouched, so a controller or a bus monitor sees exactly what the device would have accepted. All outputs are registered and reflect the command sampled at the preceding rising edge.

Top module: `sdc_cmd_checker`

## Requirements
- R1: Commands are decoded one cycle after the sampling edge on `cmd_o`. The codes are: 0 deselect (`cs_n` high), 1 no-op (ras/cas/we = 111), 2 activate (011), 3 read (101), 4 write (100), 5 precharge (010), 6 burst stop (110), 7 auto refresh (001 with `cke` high), 8 self refresh (001 with `cke` low), and 9 mode register set (000).
- R2: A legal activate opens the bank chosen by `ba` and stores all of `addr` as that bank's row on `bank_row_o` (bank b at bits b*ROW_W upward).
- R3: A read or write to a bank that is not open is flagged with reason 1.
- R4: A read or write issued fewer than T_RCD cycles after its bank's activate is flagged with reason 2. At exactly T_RCD cycles it is legal.
- R5: An activate to an open bank is flagged with reason 3. An activate is flagged with reason 2 when it falls fewer than T_RC cycles after the same bank's activate, fewer than T_RRD cycles after any activate, or fewer than T_RP cycles after that bank was precharged.
- R6: A precharge with `addr[10]` high targets every bank, and with it low targets the bank in `ba`. A targeted bank closes. It is flagged with reason 2 if any targeted open bank was activated fewer than T_RAS cycles before.
- R7: A read or write with `addr[10]` high (auto-precharge) locks its bank for BL cycles. While the bank is locked, any read, write or precharge to it is flagged with reason 3. The bank closes on the edge BL-1 cycles after the command, and T_RP is counted from that edge.
- R8: A mode register set writes the burst code from `addr[2:0]` (000 = 1, 001 = 2, 010 = 4, 011 = 8, 111 = full page). A mode register set or a self refresh issued while any bank is open is flagged with reason 3.
- R9: A burst stop is legal only while a full-page read or write burst is running. Such a burst starts with a legal read or write in full-page mode and ends with a burst stop or a precharge of its bank. Any other burst stop is flagged with reason 4.
- R10: A read or write with auto-precharge while the burst code is full page is flagged with reason 3.
- R11: `viol_o` pulses for exactly the cycle after a flagged command, and `viol_reason_o` is 0 whenever `viol_o` is low. A flagged command changes neither the open banks nor their rows.
- R12: After reset all banks are idle, `cmd_o` is 0, `viol_o` is low and the burst code is 000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge samples the pins |
| rst_n | input | 1 | Asynchronous active-low reset |
| cke | input | 1 | Clock enable level, splits the two refresh kinds |
| cs_n | input | 1 | Chip select, active low |
| ras_n | input | 1 | Row strobe, active low |
| cas_n | input | 1 | Column strobe, active low |
| we_n | input | 1 | Write enable, active low |
| ba | input | BA_W | Bank address |
| addr | input | ROW_W | Row / column / mode address; bit AP_BIT is the precharge qualifier |
| cmd_o | output | 4 | Decoded command code |
| bank_open_o | output | NUM_BANKS | One flag per open bank |
| bank_row_o | output | NUM_BANKS*ROW_W | Row held by each bank |
| viol_o | output | 1 | Illegal command pulse |
| viol_reason_o | output | 3 | 0 none, 1 bank not open, 2 too early, 3 illegal in state, 4 burst stop illegal |

## Verification
An auto-precharge can finish and close one bank on the same edge that a new command to the other bank is judged. The bench provokes this by issuing a write with auto-precharge to bank 1 with burst length 4. Three cycles later it issues a read to bank 0, exactly on the closing edge. The read must be accepted with no violation, and the open mask must drop to bank 0 alone in that same cycle. The next activate to bank 1 must then be reported too early, which confirms that the precharge interval started on that shared edge.

// File: rtl/sdc_pkg.sv
package sdc_pkg;

    typedef enum logic [3:0] {
        CMD_DESEL = 4'd0,
        CMD_NOP   = 4'd1,
        CMD_ACT   = 4'd2,
        CMD_RD    = 4'd3,
        CMD_WR    = 4'd4,
        CMD_PRE   = 4'd5,
        CMD_BST   = 4'd6,
        CMD_AREF  = 4'd7,
        CMD_SREF  = 4'd8,
        CMD_MRS   = 4'd9
    } sdc_cmd_e;

    typedef enum logic [2:0] {
        VR_NONE     = 3'd0,
        VR_NOT_OPEN = 3'd1,
        VR_EARLY    = 3'd2,
        VR_STATE    = 3'd3,
        VR_BST      = 3'd4
    } sdc_viol_e;

    localparam logic [2:0] BL_CODE_FULL = 3'b111;

    // burst length in cycles for a mode code; full page and reserved give 0
    function automatic logic [3:0] bl_cycles(input logic [2:0] code);
        case (code)
            3'b000:  bl_cycles = 4'd1;
            3'b001:  bl_cycles = 4'd2;
            3'b010:  bl_cycles = 4'd4;
            3'b011:  bl_cycles = 4'd8;
            default: bl_cycles = 4'd0;
        endcase
    endfunction

endpackage

// File: rtl/sdc_cmd_decode.sv
module sdc_cmd_decode
    import sdc_pkg::*;
(
    input  logic     cke,
    input  logic     cs_n,
    input  logic     ras_n,
    input  logic     cas_n,
    input  logic     we_n,
    output sdc_cmd_e cmd_o
);

    always_comb begin
        if (cs_n) begin
            cmd_o = CMD_DESEL;
        end else begin
            case ({ras_n, cas_n, we_n})
                3'b111:  cmd_o = CMD_NOP;
                3'b011:  cmd_o = CMD_ACT;
                3'b101:  cmd_o = CMD_RD;
                3'b100:  cmd_o = CMD_WR;
                3'b010:  cmd_o = CMD_PRE;
                3'b110:  cmd_o = CMD_BST;
                3'b001:  cmd_o = cke ? CMD_AREF : CMD_SREF;
                default: cmd_o = CMD_MRS;
            endcase
        end
    end

endmodule

// File: rtl/sdc_bank_track.sv
module sdc_bank_track #(
    parameter int ROW_W  = 11,
    parameter int CNT_W  = 4,
    parameter int LOCK_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              act_i,
    input  logic [ROW_W-1:0]  row_i,
    input  logic              close_i,
    input  logic              rw_i,
    input  logic              ap_i,
    input  logic              fp_mode_i,
    input  logic [LOCK_W-1:0] bl_i,
    input  logic              bst_i,
    output logic              open_o,
    output logic [ROW_W-1:0]  row_o,
    output logic [CNT_W-1:0]  act_age_o,
    output logic [CNT_W-1:0]  pre_age_o,
    output logic              locked_o,
    output logic              fp_o
);

    typedef struct packed {
        logic              open;
        logic [ROW_W-1:0]  row;
        logic [CNT_W-1:0]  act_age;
        logic [CNT_W-1:0]  pre_age;
        logic              pend;
        logic [LOCK_W-1:0] lock;
        logic              fp;
    } bank_st_t;

    bank_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (st_q.act_age != '1) st_d.act_age = st_q.act_age + CNT_W'(1);
        if (st_q.pre_age != '1) st_d.pre_age = st_q.pre_age + CNT_W'(1);
        if (st_q.pend) begin
            st_d.lock = st_q.lock - LOCK_W'(1);
            if (st_q.lock == LOCK_W'(1)) begin
                st_d.open    = 1'b0;
                st_d.pend    = 1'b0;
                st_d.pre_age = CNT_W'(1);
            end
        end
        if (act_i) begin
            st_d.open    = 1'b1;
            st_d.row     = row_i;
            st_d.act_age = CNT_W'(1);
        end
        if (close_i && st_q.open) begin
            st_d.open    = 1'b0;
            st_d.fp      = 1'b0;
            st_d.pre_age = CNT_W'(1);
        end
        if (rw_i) begin
            st_d.fp = fp_mode_i && !ap_i;
            if (ap_i) begin
                if (bl_i <= LOCK_W'(1)) begin
                    st_d.open    = 1'b0;
                    st_d.pre_age = CNT_W'(1);
                end else begin
                    st_d.pend = 1'b1;
                    st_d.lock = bl_i - LOCK_W'(1);
                end
            end
        end
        if (bst_i) st_d.fp = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q         <= '0;
            st_q.act_age <= '1;
            st_q.pre_age <= '1;
        end else begin
            st_q <= st_d;
        end
    end

    assign open_o    = st_q.open;
    assign row_o     = st_q.row;
    assign act_age_o = st_q.act_age;
    assign pre_age_o = st_q.pre_age;
    assign locked_o  = st_q.pend;
    assign fp_o      = st_q.fp;

    // R2: an accepted activate leaves the bank open holding the sampled row
    a_r2_act_opens: assert property (@(posedge clk) disable iff (!rst_n)
        act_i |=> (open_o && row_o == $past(row_i)));

    // R7: a pending auto-precharge only exists on an open bank
    a_r7_lock_on_open: assert property (@(posedge clk) disable iff (!rst_n)
        locked_o |-> open_o);

    // R7: a pending auto-precharge always has cycles left to run
    a_r7_lock_count: assert property (@(posedge clk) disable iff (!rst_n)
        locked_o |-> (st_q.lock != '0));

endmodule

// File: rtl/sdc_cmd_checker.sv
module sdc_cmd_checker
    import sdc_pkg::*;
#(
    parameter int NUM_BANKS = 2,
    parameter int ROW_W     = 11,
    parameter int AP_BIT    = 10,
    parameter int T_RCD     = 2,
    parameter int T_RC      = 7,
    parameter int T_RRD     = 2,
    parameter int T_RP      = 2,
    parameter int T_RAS     = 5,
    localparam int BA_W     = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       cke,
    input  logic                       cs_n,
    input  logic                       ras_n,
    input  logic                       cas_n,
    input  logic                       we_n,
    input  logic [BA_W-1:0]            ba,
    input  logic [ROW_W-1:0]           addr,
    output logic [3:0]                 cmd_o,
    output logic [NUM_BANKS-1:0]       bank_open_o,
    output logic [NUM_BANKS*ROW_W-1:0] bank_row_o,
    output logic                       viol_o,
    output logic [2:0]                 viol_reason_o
);

    localparam int T_MAX  = (T_RC > T_RAS ? T_RC : T_RAS) + T_RCD + T_RRD + T_RP;
    localparam int CNT_W  = $clog2(T_MAX + 1) + 1;
    localparam int LOCK_W = 4;

    typedef struct packed {
        sdc_cmd_e         cmd;
        logic             viol;
        sdc_viol_e        reason;
        logic [2:0]       bl_code;
        logic [CNT_W-1:0] rrd_age;
    } top_st_t;

    top_st_t st_d, st_q;
    sdc_cmd_e cmd_w;

    logic [NUM_BANKS-1:0] open_w, locked_w, fp_w;
    logic [NUM_BANKS-1:0] act_s, close_s, rw_s;
    logic [CNT_W-1:0]     act_age_w [NUM_BANKS];
    logic [CNT_W-1:0]     pre_age_w [NUM_BANKS];
    logic                 fp_mode, ap, bst_s, ok;
    logic [LOCK_W-1:0]    bl_cyc;

    sdc_cmd_decode u_dec (
        .cke   (cke),
        .cs_n  (cs_n),
        .ras_n (ras_n),
        .cas_n (cas_n),
        .we_n  (we_n),
        .cmd_o (cmd_w)
    );

    assign fp_mode = (st_q.bl_code == BL_CODE_FULL);
    assign bl_cyc  = bl_cycles(st_q.bl_code);
    assign ap      = addr[AP_BIT];

    always_comb begin
        logic pre_state, pre_early;
        st_d      = st_q;
        st_d.cmd  = cmd_w;
        st_d.reason = VR_NONE;
        pre_state = 1'b0;
        pre_early = 1'b0;
        for (int b = 0; b < NUM_BANKS; b++) begin
            if (ap || ba == BA_W'(b)) begin
                if (locked_w[b]) pre_state = 1'b1;
                else if (open_w[b] && act_age_w[b] < CNT_W'(T_RAS)) pre_early = 1'b1;
            end
        end
        case (cmd_w)
            CMD_ACT: begin
                if (open_w[ba]) st_d.reason = VR_STATE;
                else if (act_age_w[ba] < CNT_W'(T_RC) || st_q.rrd_age < CNT_W'(T_RRD)
                         || pre_age_w[ba] < CNT_W'(T_RP)) st_d.reason = VR_EARLY;
            end
            CMD_RD, CMD_WR: begin
                if (!open_w[ba]) st_d.reason = VR_NOT_OPEN;
                else if (locked_w[ba] || (ap && fp_mode)) st_d.reason = VR_STATE;
                else if (act_age_w[ba] < CNT_W'(T_RCD)) st_d.reason = VR_EARLY;
            end
            CMD_PRE: begin
                if (pre_state) st_d.reason = VR_STATE;
                else if (pre_early) st_d.reason = VR_EARLY;
            end
            CMD_BST: begin
                if (fp_w == '0) st_d.reason = VR_BST;
            end
            CMD_SREF, CMD_MRS: begin
                if (open_w != '0) st_d.reason = VR_STATE;
            end
            default: st_d.reason = VR_NONE;
        endcase
        ok        = (st_d.reason == VR_NONE);
        st_d.viol = !ok;
        for (int b = 0; b < NUM_BANKS; b++) begin
            act_s[b]   = ok && cmd_w == CMD_ACT && ba == BA_W'(b);
            close_s[b] = ok && cmd_w == CMD_PRE && (ap || ba == BA_W'(b));
            rw_s[b]    = ok && (cmd_w == CMD_RD || cmd_w == CMD_WR) && ba == BA_W'(b);
        end
        bst_s = ok && cmd_w == CMD_BST;
        if (ok && cmd_w == CMD_MRS) st_d.bl_code = addr[2:0];
        if (ok && cmd_w == CMD_ACT) st_d.rrd_age = CNT_W'(1);
        else if (st_q.rrd_age != '1) st_d.rrd_age = st_q.rrd_age + CNT_W'(1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q         <= '0;
            st_q.cmd     <= CMD_DESEL;
            st_q.reason  <= VR_NONE;
            st_q.rrd_age <= '1;
        end else begin
            st_q <= st_d;
        end
    end

    for (genvar g = 0; g < NUM_BANKS; g++) begin : g_bank
        sdc_bank_track #(
            .ROW_W  (ROW_W),
            .CNT_W  (CNT_W),
            .LOCK_W (LOCK_W)
        ) u_bank (
            .clk       (clk),
            .rst_n     (rst_n),
            .act_i     (act_s[g]),
            .row_i     (addr),
            .close_i   (close_s[g]),
            .rw_i      (rw_s[g]),
            .ap_i      (ap),
            .fp_mode_i (fp_mode),
            .bl_i      (bl_cyc),
            .bst_i     (bst_s),
            .open_o    (open_w[g]),
            .row_o     (bank_row_o[g*ROW_W +: ROW_W]),
            .act_age_o (act_age_w[g]),
            .pre_age_o (pre_age_w[g]),
            .locked_o  (locked_w[g]),
            .fp_o      (fp_w[g])
        );
    end

    assign cmd_o         = st_q.cmd;
    assign viol_o        = st_q.viol;
    assign viol_reason_o = st_q.reason;
    assign bank_open_o   = open_w;

    // R11: a flagged command leaves every stored row untouched
    a_r11_rows_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        viol_o |-> $stable(bank_row_o));

    // R11: reason code is present exactly when the pulse is
    a_r11_reason_pairs: assert property (@(posedge clk) disable iff (!rst_n)
        viol_o == (viol_reason_o != 3'd0));

    // R8: an accepted mode register set finds and leaves all banks idle
    a_r8_mrs_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_o == CMD_MRS && !viol_o) |-> (bank_open_o == '0));

    // R9: an accepted burst stop leaves no full-page burst running
    a_r9_bst_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_o == CMD_BST && !viol_o) |-> (fp_w == '0));

endmodule

// File: tb/sdc_cmd_checker_tb.sv
module sdc_cmd_checker_tb;

    localparam logic [3:0] C_DESEL = 4'd0, C_NOP = 4'd1, C_ACT = 4'd2, C_RD = 4'd3,
                           C_WR = 4'd4, C_PRE = 4'd5, C_BST = 4'd6, C_AREF = 4'd7,
                           C_SREF = 4'd8, C_MRS = 4'd9;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cke = 1'b1, cs_n = 1'b1, ras_n = 1'b1, cas_n = 1'b1, we_n = 1'b1;
    logic [0:0]  ba = '0;
    logic [10:0] addr = '0;
    logic [3:0]  cmd_o;
    logic [1:0]  bank_open_o;
    logic [21:0] bank_row_o;
    logic        viol_o;
    logic [2:0]  viol_reason_o;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    typedef struct packed {
        logic [3:0]  cmd;
        logic [2:0]  rsn;
        logic [1:0]  open;
        logic        chk_row;
        logic        rb;
        logic [10:0] row;
    } exp_t;

    exp_t  q_exp [$];
    string q_tag [$];

    always #5 clk = ~clk;

    sdc_cmd_checker u_dut (
        .clk           (clk),
        .rst_n         (rst_n),
        .cke           (cke),
        .cs_n          (cs_n),
        .ras_n         (ras_n),
        .cas_n         (cas_n),
        .we_n          (we_n),
        .ba            (ba),
        .addr          (addr),
        .cmd_o         (cmd_o),
        .bank_open_o   (bank_open_o),
        .bank_row_o    (bank_row_o),
        .viol_o        (viol_o),
        .viol_reason_o (viol_reason_o)
    );

    task automatic issue(input logic [3:0] c, input logic b, input logic [10:0] a,
                         input logic [2:0] rsn, input logic [1:0] open,
                         input logic chk_row, input logic [10:0] row, input string tag);
        exp_t e;
        @(negedge clk);
        cke = 1'b1; cs_n = 1'b0; ba = b; addr = a;
        case (c)
            C_DESEL: cs_n = 1'b1;
            C_NOP:   {ras_n, cas_n, we_n} = 3'b111;
            C_ACT:   {ras_n, cas_n, we_n} = 3'b011;
            C_RD:    {ras_n, cas_n, we_n} = 3'b101;
            C_WR:    {ras_n, cas_n, we_n} = 3'b100;
            C_PRE:   {ras_n, cas_n, we_n} = 3'b010;
            C_BST:   {ras_n, cas_n, we_n} = 3'b110;
            C_AREF:  {ras_n, cas_n, we_n} = 3'b001;
            C_SREF:  begin {ras_n, cas_n, we_n} = 3'b001; cke = 1'b0; end
            default: {ras_n, cas_n, we_n} = 3'b000;
        endcase
        e.cmd = c; e.rsn = rsn; e.open = open; e.chk_row = chk_row; e.rb = b; e.row = row;
        q_exp.push_back(e);
        q_tag.push_back(tag);
    endtask

    task automatic nop(input logic [1:0] open, input string tag);
        issue(C_NOP, 1'b0, 11'h0, 3'd0, open, 1'b0, 11'h0, tag);
    endtask

    // monitor: compares each result one cycle after its command was sampled
    always @(posedge clk) begin
        #2;
        if (q_exp.size() > 0) begin
            exp_t  e;
            string t;
            e = q_exp.pop_front();
            t = q_tag.pop_front();
            checks++;
            if (cmd_o !== e.cmd || viol_o !== (e.rsn != 3'd0) || viol_reason_o !== e.rsn
                || bank_open_o !== e.open) begin
                failures++;
                $display("FAIL %s: cmd=%0d viol=%0b rsn=%0d open=%b expected cmd=%0d rsn=%0d open=%b",
                         t, cmd_o, viol_o, viol_reason_o, bank_open_o, e.cmd, e.rsn, e.open);
            end
            if (e.chk_row) begin
                checks++;
                if (bank_row_o[e.rb*11 +: 11] !== e.row) begin
                    failures++;
                    $display("FAIL %s: row[%0d]=%h expected %h", t, e.rb,
                             bank_row_o[e.rb*11 +: 11], e.row);
                end
            end
        end
    end

    task automatic check_reset;
        checks++;
        if (cmd_o !== 4'd0 || viol_o !== 1'b0 || viol_reason_o !== 3'd0 || bank_open_o !== 2'b00) begin
            failures++;
            $display("FAIL R12: cmd=%0d viol=%0b rsn=%0d open=%b expected 0 0 0 00",
                     cmd_o, viol_o, viol_reason_o, bank_open_o);
        end
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check_reset();                                              // R12
        nop(2'b00, "R1 nop");
        issue(C_DESEL, 0, 11'h0,   3'd0, 2'b00, 0, 11'h0,   "R1 deselect");
        issue(C_RD,    0, 11'h0,   3'd1, 2'b00, 0, 11'h0,   "R3 read idle");
        issue(C_MRS,   0, 11'h002, 3'd0, 2'b00, 0, 11'h0,   "R8 mrs bl4");
        issue(C_ACT,   0, 11'h155, 3'd0, 2'b01, 1, 11'h155, "R2 act b0");
        issue(C_ACT,   1, 11'h2AA, 3'd2, 2'b01, 0, 11'h0,   "R5 trrd early");
        issue(C_RD,    0, 11'h010, 3'd0, 2'b01, 0, 11'h0,   "R4 trcd exact");
        issue(C_ACT,   1, 11'h2AA, 3'd0, 2'b11, 1, 11'h2AA, "R2 act b1");
        issue(C_ACT,   1, 11'h111, 3'd3, 2'b11, 1, 11'h2AA, "R5 act open bank");
        issue(C_MRS,   0, 11'h000, 3'd3, 2'b11, 0, 11'h0,   "R8 mrs with open bank");
        issue(C_PRE,   0, 11'h000, 3'd0, 2'b10, 0, 11'h0,   "R6 pre single");
        issue(C_ACT,   0, 11'h0F0, 3'd2, 2'b10, 0, 11'h0,   "R5 trp early");
        issue(C_ACT,   0, 11'h0F0, 3'd0, 2'b11, 1, 11'h0F0, "R5 act after trp");
        issue(C_PRE,   0, 11'h400, 3'd2, 2'b11, 1, 11'h0F0, "R6 R11 pre all before tras");
        issue(C_WR,    1, 11'h400, 3'd0, 2'b11, 0, 11'h0,   "R7 write autopre");
        issue(C_RD,    1, 11'h004, 3'd3, 2'b11, 0, 11'h0,   "R7 read locked bank");
        issue(C_RD,    0, 11'h008, 3'd0, 2'b11, 0, 11'h0,   "R7 other bank free");
        issue(C_RD,    0, 11'h00C, 3'd0, 2'b01, 0, 11'h0,   "R7 close same edge");
        issue(C_ACT,   1, 11'h3C3, 3'd2, 2'b01, 0, 11'h0,   "R7 trp after autopre");
        issue(C_ACT,   1, 11'h3C3, 3'd0, 2'b11, 1, 11'h3C3, "R2 act b1 again");
        issue(C_BST,   0, 11'h000, 3'd4, 2'b11, 0, 11'h0,   "R9 bst no full page");
        for (int i = 0; i < 4; i++) nop(2'b11, "R1 nop gap");
        issue(C_PRE,   1, 11'h400, 3'd0, 2'b00, 0, 11'h0,   "R6 pre all");
        issue(C_MRS,   0, 11'h007, 3'd0, 2'b00, 0, 11'h0,   "R8 mrs full page");
        issue(C_ACT,   0, 11'h001, 3'd0, 2'b01, 1, 11'h001, "R2 act b0 full page");
        nop(2'b01, "R1 nop");
        issue(C_RD,    0, 11'h400, 3'd3, 2'b01, 0, 11'h0,   "R10 autopre full page");
        issue(C_RD,    0, 11'h000, 3'd0, 2'b01, 0, 11'h0,   "R9 full page read");
        issue(C_BST,   0, 11'h000, 3'd0, 2'b01, 0, 11'h0,   "R9 bst legal");
        issue(C_BST,   0, 11'h000, 3'd4, 2'b01, 0, 11'h0,   "R9 bst after stop");
        issue(C_SREF,  0, 11'h000, 3'd3, 2'b01, 0, 11'h0,   "R8 sref with open bank");
        issue(C_AREF,  0, 11'h000, 3'd0, 2'b01, 0, 11'h0,   "R1 auto refresh");
        issue(C_PRE,   0, 11'h000, 3'd0, 2'b00, 0, 11'h0,   "R6 pre b0");
        issue(C_SREF,  0, 11'h000, 3'd0, 2'b00, 0, 11'h0,   "R8 sref idle");
        issue(C_WR,    0, 11'h000, 3'd1, 2'b00, 0, 11'h0,   "R3 write idle");
        nop(2'b00, "R11 pulse ends");
        repeat (3) @(posedge clk);
        #3;
        if (!done) begin
            done = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        #200us;
        if (!done) begin
            done = 1'b1;
            failures++;
            $display("FAIL watchdog: run did not finish, expected completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule